// File: doc/BRIEF.md
# ADC Conversion Control Interface Model

A synchronous, clocked stand-in for the digital control side of a successive-approximation converter. It is used to verify a host controller that drives an active-low chip select and a read/convert line. Together those two lines decide whether the part converts, drives its data bus, or stays off the bus. A conversion lasts a parameterised number of clocks. During it, the busy output is held low and further convert commands are ignored. The result word is taken from a parallel sample input.

The model keeps the most recently completed word. A read issued while a conversion runs returns that older word (conversion n-1). A read after busy returns high gets the new word (conversion n). Two kinds of host error are modelled. The first is a convert command that arrives while a conversion is running. The second is a new conversion that starts before the input has had enough acquisition time, which includes the case where the control lines are still low at the moment busy rises. Each word carries an invalid flag for the second case.

Top module: `adc_ctrl_model`

## Requirements
- R1: While rst_ni is low, and after its release until the first stimulus, busy_no is 1 and data_oe_o, data_o, data_invalid_o and misuse_o are all 0.
- R2: While cs_ni is 1, changes on rc_i start no conversion (busy_no stays 1), and data_oe_o stays 0 with data_o at 0.
- R3: The hold condition is cs_ni low together with rc_i low. When it becomes true on a clock edge while idle, a conversion starts, whichever line fell last. busy_no reads 0 from that edge for exactly CONV_CYCLES cycles. data_oe_o is 0 during the first cycle of the conversion.
- R4: data_oe_o is 1 one clock after an edge that samples cs_ni low and rc_i high. While data_oe_o is 0, data_o is 0.
- R5: A read while busy_no is 0 drives the word of the previously completed conversion.
- R6: After busy_no returns to 1, the bus drives sample_i as captured on the edge where the conversion started.
- R7: A hold condition that rises while busy_no is 0 neither extends nor restarts the conversion. It makes misuse_o read 1 for exactly one cycle, starting one clock later.
- R8: If the hold condition is still true on the edge where a conversion completes, busy_no stays 0. A second conversion of CONV_CYCLES runs, capturing sample_i on that edge, and its word reads with data_invalid_o = 1. The first word keeps data_invalid_o = 0.
- R9: A conversion that starts fewer than ACQ_CYCLES clock edges after the edge on which busy_no rose yields data_invalid_o = 1. A start at ACQ_CYCLES or more edges, or the first start after reset, yields 0.
- R10: With cs_ni held low, raising rc_i enables the bus on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Low requests a conversion, high requests a read |
| sample_i | input | DATA_W | Value the converter would produce |
| busy_no | output | 1 | Low while a conversion runs |
| data_oe_o | output | 1 | Bus drive enable (low means high impedance) |
| data_o | output | DATA_W | Result word, 0 when not driven |
| data_invalid_o | output | 1 | Word on record came from a short-acquisition conversion |
| misuse_o | output | 1 | One-cycle pulse for an ignored convert command |

## Verification
Suppose the cycle counter or the busy register is corrupted. busy_no would then stretch, shrink or retrigger, and the bench sees this within one conversion, because it counts the exact number of low cycles for every start. A wrong sample or word register shows up on the first read after busy rises, or on the first read during the following conversion, where the n-1 word is expected. A wrong acquisition counter changes data_invalid_o on the very next conversion. The table-driven starts probe gaps on both sides of the ACQ_CYCLES threshold.

// File: rtl/adc_bfm_pkg.sv
package adc_bfm_pkg;
  typedef struct packed {
    logic hold;
    logic start;
  } ctl_ev_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/adc_ctl_decode.sv
module adc_ctl_decode
  import adc_bfm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_ni,
  input  logic    rc_i,
  input  logic    busy_i,
  output ctl_ev_t ev_o,
  output logic    oe_o,
  output logic    misuse_o
);
  logic hold_q, oe_q, misuse_q;
  logic hold, hold_rise;

  assign hold      = ~cs_ni & ~rc_i;
  assign hold_rise = hold & ~hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      oe_q     <= 1'b0;
      misuse_q <= 1'b0;
    end else begin
      hold_q   <= hold;
      oe_q     <= ~cs_ni & rc_i;
      misuse_q <= hold_rise & busy_i;
    end
  end

  assign ev_o.hold  = hold;
  assign ev_o.start = hold_rise & ~busy_i;
  assign oe_o       = oe_q;
  assign misuse_o   = misuse_q;

  p_bus_off_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !oe_q);
  p_misuse_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misuse_q |=> !misuse_q);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_bfm_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned ACQ_CYCLES  = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ctl_ev_t ev_i,
  output logic    busy_o,
  output logic    done_o,
  output logic    capture_o,
  output logic    short_o
);
  localparam int unsigned CNT_W = cnt_width(CONV_CYCLES);
  localparam int unsigned ACQ_W = cnt_width(ACQ_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [ACQ_W-1:0] ACQ_FULL = ACQ_W'(ACQ_CYCLES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACQ_W-1:0] acq_q;
  logic             done, restart;

  assign done    = busy_q & (cnt_q == '0);
  assign restart = done & ev_i.hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ev_i.start || restart) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // edges elapsed since busy ended, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       acq_q <= ACQ_FULL;
    else if (done && !ev_i.hold)       acq_q <= ACQ_W'(1);
    else if (!busy_q && acq_q < ACQ_FULL) acq_q <= acq_q + 1'b1;
  end

  assign busy_o    = busy_q;
  assign done_o    = done;
  assign capture_o = ev_i.start | restart;
  assign short_o   = restart | (acq_q < ACQ_FULL);

  p_no_retrigger_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.start |-> !busy_q);
  p_restart_short_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> busy_q && cnt_q == CNT_LOAD);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              short_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] word_o,
  output logic              invalid_o
);
  logic [DATA_W-1:0] held_q, word_q;
  logic              held_short_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q       <= '0;
      held_short_q <= 1'b0;
    end else if (capture_i) begin
      held_q       <= sample_i;
      held_short_q <= short_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      inv_q  <= 1'b0;
    end else if (done_i) begin
      word_q <= held_q;
      inv_q  <= held_short_q;
    end
  end

  assign word_o    = word_q;
  assign invalid_o = inv_q;

  p_word_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(word_q) && $stable(inv_q));
endmodule

// File: rtl/adc_ctrl_model.sv
module adc_ctrl_model
  import adc_bfm_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned ACQ_CYCLES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rc_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_no,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_invalid_o,
  output logic              misuse_o
);
  ctl_ev_t           ev;
  logic              busy, done, capture, short_acq, oe;
  logic [DATA_W-1:0] word;

  adc_ctl_decode u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .rc_i    (rc_i),
    .busy_i  (busy),
    .ev_o    (ev),
    .oe_o    (oe),
    .misuse_o(misuse_o)
  );

  adc_conv_seq #(
    .CONV_CYCLES(CONV_CYCLES),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .busy_o   (busy),
    .done_o   (done),
    .capture_o(capture),
    .short_o  (short_acq)
  );

  adc_result_regs #(
    .DATA_W(DATA_W)
  ) u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .short_i  (short_acq),
    .done_i   (done),
    .sample_i (sample_i),
    .word_o   (word),
    .invalid_o(data_invalid_o)
  );

  assign busy_no   = ~busy;
  assign data_oe_o = oe;
  assign data_o    = oe ? word : '0;

  p_bus_off_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> !data_oe_o);
  p_misuse_in_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misuse_o |-> !busy_no);
endmodule

// File: tb/tb_adc_ctrl_model.sv
module tb_adc_ctrl_model;
  localparam int DW   = 16;
  localparam int CONV = 6;
  localparam int ACQ  = 4;
  localparam int NV   = 7;

  localparam logic [DW-1:0] V_SMP [NV] = '{16'hA5A5, 16'h1234, 16'hFFFF, 16'h0001,
                                           16'h8000, 16'h7FFE, 16'h0000};
  localparam int            V_GAP [NV] = '{1, 1, 4, 3, 5, 2, 4};
  localparam bit            V_INV [NV] = '{0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rc = 1'b1;
  logic [DW-1:0] smp = '0;
  logic busy_n, oe, inv, mis;
  logic [DW-1:0] dat;

  int checks = 0, fails = 0;
  logic [DW-1:0] last_word = '0;

  always #2 clk = ~clk;

  adc_ctrl_model #(.DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rc_i(rc), .sample_i(smp),
    .busy_no(busy_n), .data_oe_o(oe), .data_o(dat),
    .data_invalid_o(inv), .misuse_o(mis)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // start already driven; counts low cycles of busy_no up to the edge where it rises
  task automatic wait_busy(input string req, input int exp_len);
    int n = 0;
    while (!busy_n && n < 100) begin
      n++;
      tick();
    end
    chk(n == exp_len, req, "busy length", n, exp_len);
  endtask

  task automatic run_conv(input logic [DW-1:0] s, input int gap, input bit exp_inv);
    int n;
    repeat (gap - 1) tick();
    cs_n = 1'b0; rc = 1'b0; smp = s;
    tick();
    chk(!busy_n, "R3", "busy after start", busy_n, 0);
    chk(!oe, "R3", "bus off at start", oe, 0);
    rc = 1'b1; smp = ~s;
    tick();
    chk(oe && dat == last_word, "R5", "n-1 read", dat, last_word);
    n = 2;
    while (!busy_n && n < 100) begin
      tick();
      if (!busy_n) n++;
    end
    chk(n == CONV, "R3", "busy length", n, CONV);
    chk(dat == s, "R6", "word n", dat, s);
    chk(inv == exp_inv, "R9", "invalid flag", inv, exp_inv);
    last_word = s;
    cs_n = 1'b1;
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    chk(busy_n && !oe && dat == 0 && !inv && !mis, "R1", "in reset",
        {busy_n, oe, inv, mis}, 4'b1000);
    rst_n = 1'b1;
    tick();
    chk(busy_n && !oe && dat == 0 && !inv && !mis, "R1", "after reset",
        {busy_n, oe, inv, mis}, 4'b1000);

    // table of starts at varying acquisition gaps
    for (int i = 0; i < NV; i++) run_conv(V_SMP[i], V_GAP[i], V_INV[i]);

    // R2: chip select high, read/convert toggles
    for (int i = 0; i < 6; i++) begin
      rc = i[0];
      tick();
      chk(busy_n && !oe && dat == 0, "R2", "deselected", {busy_n, oe}, 2'b10);
    end

    // R10 / R4: cs low, rc high enables bus one edge later
    rc = 1'b1;
    cs_n = 1'b0;
    tick();
    chk(oe && dat == last_word, "R10", "read with cs low", dat, last_word);
    cs_n = 1'b1;
    tick();
    chk(!oe && dat == 0, "R4", "bus off after deselect", oe, 0);

    // R3: rc low first, cs initiates conversion
    rc = 1'b0;
    tick();
    chk(busy_n, "R2", "rc low alone no start", busy_n, 1);
    cs_n = 1'b0; smp = 16'h3C3C;
    tick();
    chk(!busy_n && !oe, "R3", "cs-initiated start", {busy_n, oe}, 0);
    rc = 1'b1; smp = 16'h0;
    n = 1;
    while (!busy_n && n < 100) begin
      tick();
      if (!busy_n) n++;
    end
    chk(n == CONV, "R3", "cs-start busy length", n, CONV);
    chk(dat == 16'h3C3C && !inv, "R6", "cs-start word", dat, 16'h3C3C);
    last_word = 16'h3C3C;
    cs_n = 1'b1;

    // R7: convert command during busy ignored
    repeat (ACQ + 1) tick();
    cs_n = 1'b0; rc = 1'b0; smp = 16'h5A5A;
    tick();
    rc = 1'b1; smp = 16'h1111;
    tick();
    rc = 1'b0;
    tick();
    chk(mis, "R7", "misuse pulse", mis, 1);
    rc = 1'b1;
    tick();
    chk(!mis, "R7", "misuse one cycle", mis, 0);
    n = 4;
    while (!busy_n && n < 100) begin
      tick();
      if (!busy_n) n++;
    end
    chk(n == CONV, "R7", "no extension", n, CONV);
    chk(dat == 16'h5A5A && !inv, "R7", "word unchanged by ignored cmd", dat, 16'h5A5A);
    last_word = 16'h5A5A;
    cs_n = 1'b1;

    // R8: lines still low as busy rises
    repeat (ACQ + 1) tick();
    cs_n = 1'b0; rc = 1'b0; smp = 16'hBEEF;
    tick();
    smp = 16'hCAFE;
    n = 1;
    while (n < CONV + 2) begin
      tick();
      chk(!busy_n, "R8", "busy held across restart", busy_n, 0);
      n++;
    end
    rc = 1'b1;
    tick();
    n++;
    chk(oe && dat == 16'hBEEF && !inv, "R8", "first word valid", dat, 16'hBEEF);
    while (!busy_n && n < 100) begin
      tick();
      if (!busy_n) n++;
    end
    chk(n == 2 * CONV, "R8", "double busy length", n, 2 * CONV);
    chk(dat == 16'hCAFE, "R8", "restart word", dat, 16'hCAFE);
    chk(inv, "R8", "restart word invalid", inv, 1);
    last_word = 16'hCAFE;
    cs_n = 1'b1;

    // R9: valid conversion clears the flag
    run_conv(16'h0F0F, ACQ + 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule